// File: doc/BRIEF.md
# Modem Line Change Detector

This block is the modem-status part of a 16550-style serial port. It watches four active-low handshake inputs: clear-to-send, data-set-ready, ring indicator and carrier detect. Each input is synchronised to the core clock. The block then records a sticky change flag for each line. A read of the status register at offset 6 from the port base returns the four flags together with the present line levels, and that read clears the flags.

A level interrupt request goes high while any flag is set and the modem-status enable bit of the interrupt-enable register (supplied as an input) is 1. When hardware autoflow control is on, the clear-to-send flag is held clear, so clear-to-send changes never interrupt. A build parameter can remove ring and carrier change detection, and then those two flags read as zero.

Each flag is a two-state machine. FLAG_IDLE moves to FLAG_HELD on a detected change (the "set" transition), unless the flag is blocked. FLAG_HELD moves to FLAG_IDLE on a register read that has no fresh change in the same cycle (the "read-clear" transition), or at once while the flag is blocked (the "suppress" transition). In every other case the state stays where it is.

Top module: `modem_status_unit`

## Requirements
- R1: A change of cts_n in either direction sets bit 0 of the status register. The flag is set after the third rising clock edge that follows the change.
- R2: A change of dsr_n in either direction sets bit 1, with the same latency as R1.
- R3: Bit 2 sets only when ri_n goes from 0 to 1. A 1-to-0 change of ri_n leaves bit 2 unchanged.
- R4: A change of dcd_n in either direction sets bit 3.
- R5: Bits 7, 6, 5 and 4 return the inverted synchronised levels of dcd_n, ri_n, dsr_n and cts_n, in that order, so a 1 means the line is asserted (low).
- R6: A read (bus_rd high with bus_addr equal to 6) returns the register on rd_data in the same cycle and clears bits 3 to 0 at that clock edge. At any other address rd_data is 0 and the flags are kept.
- R7: A change detected in the same cycle as a clearing read leaves its flag set.
- R8: irq is high exactly while msi_en is 1 and any of bits 3 to 0 is 1. It is a level signal that falls when the flags clear or msi_en drops.
- R9: While autoflow_en is 1, bit 0 is held at 0 and clear-to-send changes raise no irq.
- R10: After reset, bits 3 to 0 are 0 and irq is 0.
- R11: With HAS_RI_DCD set to 0, bits 2 and 3 always read 0, while bits 7 to 4 still follow the lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W | Register offset within the port |
| rd_data | output | 8 | Status register value during a read at offset 6, else 0 |
| msi_en | input | 1 | Modem-status interrupt enable bit from the interrupt-enable register |
| autoflow_en | input | 1 | Hardware autoflow control active |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect, active low, asynchronous |
| irq | output | 1 | Modem-status interrupt request, level |

## Verification
The assertions check several rules on every cycle. A detected change sets its flag one edge later. A flag never rises without a preceding change. A clearing read with no change empties all flags, and a change that coincides with a read survives it. Autoflow keeps the clear-to-send flag at zero, and irq is never high without the enable bit and a set flag. Only the bench scenarios show the rest: the end-to-end latency through the synchronizer, the ring flag ignoring a falling ring input, the level bits and their order, reads at other offsets, and the stubbed build.

// File: rtl/msr_pkg.sv
package msr_pkg;
    localparam int NUM_LINES = 4;
    localparam int IDX_CTS   = 0;
    localparam int IDX_DSR   = 1;
    localparam int IDX_RI    = 2;
    localparam int IDX_DCD   = 3;
    localparam int REG_W     = 2 * NUM_LINES;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_HELD = 1'b1
    } flag_state_e;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] line_n,
    output logic [WIDTH-1:0] level_n,
    output logic [WIDTH-1:0] prev_n
);
    localparam int DEPTH = STAGES + 1;

    logic [WIDTH-1:0] pipe [DEPTH];

    // Idle lines sit high; reset to that level so no false change appears.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) begin
                pipe[s] <= '1;
            end
        end else begin
            pipe[0] <= line_n;
            for (int s = 1; s < DEPTH; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign level_n = pipe[STAGES-1];
    assign prev_n  = pipe[STAGES];
endmodule

// File: rtl/delta_flag.sv
module delta_flag
    import msr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic clear_i,
    input  logic block_i,
    output logic flag_o
);
    flag_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (event_i && !block_i) begin
                    state_d = FLAG_HELD;          // set
                end
            end
            FLAG_HELD: begin
                if (block_i) begin
                    state_d = FLAG_IDLE;          // suppress
                end else if (clear_i && !event_i) begin
                    state_d = FLAG_IDLE;          // read-clear
                end
            end
            default: state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            FLAG_HELD: flag_o = 1'b1;
            default:   flag_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
    import msr_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int MSR_OFFSET  = 6,
    parameter int SYNC_STAGES = 2,
    parameter bit HAS_RI_DCD  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              msi_en,
    input  logic              autoflow_en,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              dcd_n,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(MSR_OFFSET);

    logic [NUM_LINES-1:0] raw_n;
    logic [NUM_LINES-1:0] lvl_n;
    logic [NUM_LINES-1:0] prv_n;
    logic [NUM_LINES-1:0] line_evt;
    logic [NUM_LINES-1:0] line_blk;
    logic [NUM_LINES-1:0] delta_q;
    logic                 rd_hit;

    assign raw_n = {dcd_n, ri_n, dsr_n, cts_n};

    line_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_n  (raw_n),
        .level_n (lvl_n),
        .prev_n  (prv_n)
    );

    assign rd_hit = bus_rd && (bus_addr == HIT_ADDR);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (i == IDX_RI) begin : g_trail
            // Ring flag: only the line going from low to high counts.
            assign line_evt[i] = lvl_n[i] & ~prv_n[i];
        end else begin : g_any
            assign line_evt[i] = lvl_n[i] ^ prv_n[i];
        end

        if (i == IDX_CTS) begin : g_afc
            assign line_blk[i] = autoflow_en;
        end else begin : g_free
            assign line_blk[i] = 1'b0;
        end

        if (!HAS_RI_DCD && (i == IDX_RI || i == IDX_DCD)) begin : g_stub
            assign delta_q[i] = 1'b0;
        end else begin : g_flag
            delta_flag u_flag (
                .clk     (clk),
                .rst_n   (rst_n),
                .event_i (line_evt[i]),
                .clear_i (rd_hit),
                .block_i (line_blk[i]),
                .flag_o  (delta_q[i])
            );
        end
    end

    assign rd_data = rd_hit ? {~lvl_n, delta_q} : '0;
    assign irq     = msi_en & (|delta_q);
endmodule

// File: rtl/msr_checker.sv
module msr_checker #(
    parameter int ADDR_W     = 3,
    parameter int MSR_OFFSET = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              msi_en,
    input logic              autoflow_en,
    input logic              irq,
    input logic [3:0]        flags,
    input logic [3:0]        events
);
    logic hit;
    assign hit = bus_rd && (bus_addr == ADDR_W'(MSR_OFFSET));

    assert_cts_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (events[0] && !autoflow_en) |=> flags[0]);

    assert_dsr_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        events[1] |=> flags[1]);

    assert_ring_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[2]) |-> $past(events[2]));

    assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && events == 4'b0000) |=> (flags == 4'b0000));

    assert_keep_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && events[1]) |=> flags[1]);

    assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (msi_en && flags != 4'b0000));

    assert_afc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        autoflow_en |=> !flags[0]);
endmodule

bind modem_status_unit msr_checker #(
    .ADDR_W     (ADDR_W),
    .MSR_OFFSET (MSR_OFFSET)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .msi_en      (msi_en),
    .autoflow_en (autoflow_en),
    .irq         (irq),
    .flags       (delta_q),
    .events      (line_evt)
);

// File: tb/sim_modem_status_unit.sv
`timescale 1ns/1ps
module sim_modem_status_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       msi_en = 1'b0;
    logic       autoflow_en = 1'b0;
    logic       cts_n = 1'b1;
    logic       dsr_n = 1'b1;
    logic       ri_n = 1'b1;
    logic       dcd_n = 1'b1;
    logic [7:0] rd_data, rd_data1;
    logic       irq, irq1;
    logic [7:0] got, got1;
    int         total = 0;
    int         bad = 0;

    always #2.5 clk = ~clk;

    modem_status_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .rd_data(rd_data), .msi_en(msi_en), .autoflow_en(autoflow_en),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n), .irq(irq)
    );

    modem_status_unit #(.HAS_RI_DCD(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .rd_data(rd_data1), .msi_en(msi_en), .autoflow_en(autoflow_en),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n), .irq(irq1)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Entered at a falling edge; leaves at a falling edge.
    task automatic do_read(input logic [2:0] addr);
        bus_rd = 1'b1;
        bus_addr = addr;
        #1;
        got  = rd_data;
        got1 = rd_data1;
        @(negedge clk);
        bus_rd = 1'b0;
        bus_addr = 3'd0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        do_read(3'd6);
        check("R10 flags", got[3:0], 0);
        check("R10 irq", irq, 0);
    endtask

    task automatic t_cts();
        cts_n = 1'b0; settle();
        do_read(3'd6);
        check("R1 fall sets bit0", got[0], 1);
        check("R5 cts level bit4", got[4], 1);
        do_read(3'd6);
        check("R6 bit0 cleared", got[0], 0);
        cts_n = 1'b1; settle();
        do_read(3'd6);
        check("R1 rise sets bit0", got[0], 1);
        check("R5 cts level released", got[4], 0);
    endtask

    task automatic t_latency();
        dsr_n = 1'b0;
        repeat (2) @(negedge clk);
        do_read(3'd6);
        check("R2 not yet set", got[1], 0);
        do_read(3'd6);
        check("R7 change during read kept", got[1], 1);
        check("R5 dsr level bit5", got[5], 1);
        do_read(3'd6);
        check("R6 cleared after read", got[1], 0);
        dsr_n = 1'b1; settle();
        do_read(3'd6);
        check("R2 rise sets bit1", got[1], 1);
    endtask

    task automatic t_ring();
        ri_n = 1'b0; settle();
        do_read(3'd6);
        check("R3 falling ignored", got[2], 0);
        check("R5 ring level bit6", got[6], 1);
        ri_n = 1'b1; settle();
        do_read(3'd6);
        check("R3 rising sets bit2", got[2], 1);
        check("R11 stub ring zero", got1[2], 0);
    endtask

    task automatic t_dcd();
        dcd_n = 1'b0; settle();
        do_read(3'd6);
        check("R4 change sets bit3", got[3], 1);
        check("R5 dcd level bit7", got[7], 1);
        check("R11 stub dcd zero", got1[3], 0);
        check("R11 stub level bit7", got1[7], 1);
        dcd_n = 1'b1; settle();
        do_read(3'd6);
    endtask

    task automatic t_other_addr();
        dsr_n = 1'b0; settle();
        do_read(3'd5);
        check("R6 other offset reads zero", got, 0);
        do_read(3'd6);
        check("R6 other offset kept flag", got[1], 1);
        dsr_n = 1'b1; settle();
        do_read(3'd6);
    endtask

    task automatic t_irq();
        msi_en = 1'b1;
        #1 check("R8 no flag no irq", irq, 0);
        @(negedge clk);
        dsr_n = 1'b0; settle();
        check("R8 irq raised", irq, 1);
        msi_en = 1'b0;
        #1 check("R8 irq off with enable", irq, 0);
        msi_en = 1'b1;
        #1 check("R8 irq back level", irq, 1);
        @(negedge clk);
        do_read(3'd6);
        check("R8 irq drops after read", irq, 0);
        dsr_n = 1'b1; settle();
        do_read(3'd6);
    endtask

    task automatic t_autoflow();
        cts_n = 1'b0; settle();
        check("R9 pre irq", irq, 1);
        autoflow_en = 1'b1;
        @(negedge clk);
        check("R9 held flag suppressed irq", irq, 0);
        cts_n = 1'b1; settle();
        check("R9 no irq under autoflow", irq, 0);
        do_read(3'd6);
        check("R9 bit0 held zero", got[0], 0);
        autoflow_en = 1'b0;
        msi_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_cts();
        t_latency();
        t_ring();
        t_dcd();
        t_other_addr();
        t_irq();
        t_autoflow();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule